// File: doc/BRIEF.md
# Watchdog Timer with Selectable Scalers

This block is a watchdog that counts cycles of a slow, low-power clock. It divides that clock first by a short or long prescaler and then by a power-of-two postscaler, and the select for each comes from configuration pins. If software lets the full period elapse without a restart, the block raises a request. When the device is running, the request is a reset. When the device is in a low-power state (sleep or idle), the request is a wake-up, and execution resumes where it stopped.

Several events restart the count: a software clear, a completed clock switch, entry into a low-power state, exit from a low-power state, and device reset. Every input is synchronous to the watchdog clock. The block moves no data stream, so it has no valid/ready handshake, and all of its pins are plain levels or one-cycle strobes. A sticky flag records that a timeout happened and stays set until software clears it.

Top module: `wdog_timer`

## Requirements
- R1: The prescaler divides the watchdog clock by 32 when `pre_long` is 0 and by 128 when `pre_long` is 1.
- R2: The postscaler divides the prescaler output by 2^N, where N is the value on `post_sel` (0 to 15). A timeout therefore falls P*2^N enabled cycles after the last restart, where P is 32 or 128.
- R3: A one-cycle strobe on `sw_clr`, `clk_sw_done`, `lp_enter` or `lp_exit` clears both counters at the next clock edge. Device reset (`rst_n` low) also clears them. After a strobe captured at edge E, the next timeout falls at edge E+P*2^N.
- R4: If a clear strobe is present in the same cycle as the terminal count, the clear takes priority and no request or flag update results.
- R5: A timeout with `in_lowpower` low raises `rst_req` for exactly one cycle, on the edge after the terminal count. The counters then restart from zero, so timeouts repeat every P*2^N cycles.
- R6: A timeout with `in_lowpower` high raises `wake_req` instead of `rst_req`. Counting continues while the device is in a low-power state. The two requests are never high together.
- R7: `to_flag` goes high with any timeout and stays high until a `flag_clr` strobe. If a timeout and `flag_clr` arrive in the same cycle, the flag ends up set.
- R8: While `en` is low, both counters are held at zero and no request is raised. After `en` rises at edge E, the first timeout falls at edge E+P*2^N.
- R9: `osc_en`, the enable for the watchdog clock source, follows `en`.
- R10: During and after reset, `rst_req`, `wake_req` and `to_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog (low-power) clock |
| rst_n | input | 1 | Device reset, active low |
| en | input | 1 | Watchdog enable |
| pre_long | input | 1 | Prescaler select: 0 gives divide by 32, 1 gives divide by 128 |
| post_sel | input | 4 | Postscaler exponent N (divide by 2^N) |
| sw_clr | input | 1 | Software restart strobe |
| clk_sw_done | input | 1 | Clock-switch-complete strobe |
| lp_enter | input | 1 | Strobe for entering sleep or idle |
| lp_exit | input | 1 | Strobe for leaving sleep or idle |
| in_lowpower | input | 1 | High while the device is in sleep or idle |
| flag_clr | input | 1 | Software clear of the timeout flag |
| osc_en | output | 1 | Enable for the watchdog clock source |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
The bench drives a clear strobe into the exact cycle in which the terminal count is reached. A design that let the timeout win would raise a request one edge later. The bench also restarts the count mid-period with each kind of clear strobe; a design that ignored one of these strobes would time out early against the schedule. A flag clear that lands on the timeout edge must leave the flag set, and a design that lets the clear win would leave the flag low. Finally, the bench disables the watchdog, re-enables it, changes the scaler selects at a restart, and alternates between run and low-power modes. A wrong divisor, a count that drifts after a timeout, or a swapped reset and wake request all show up as a request at the wrong cycle or of the wrong kind.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_SHORT_LOG = 5;
  localparam int PRE_LONG_LOG  = 7;
  localparam int SEL_W         = 4;
  localparam int POST_W        = (1 << SEL_W) - 1;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_RESET = 2'd1,
    REQ_WAKE  = 2'd2
  } req_kind_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic long_sel,
  output logic tick
);
  localparam int W = LONG_LOG;
  localparam logic [W-1:0] LIM_SHORT = W'((1 << SHORT_LOG) - 1);
  localparam logic [W-1:0] LIM_LONG  = W'((1 << LONG_LOG) - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit = long_sel ? LIM_LONG : LIM_SHORT;
  // >= keeps the wrap safe if the select shrinks mid-count
  assign tick  = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr || !run)   cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             term
);
  localparam int POST_W = (1 << SEL_W) - 1;

  logic [POST_W-1:0] cnt;
  logic [POST_W-1:0] mask;

  // mask has the low N bits set for a select of N
  for (genvar g = 0; g < POST_W; g++) begin : g_mask
    assign mask[g] = (sel > SEL_W'(g));
  end

  assign term = tick && (cnt == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (term)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_report.sv
module wdog_report
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic term,
  input  logic restart,
  input  logic lowpwr,
  input  logic flag_clr,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag
);
  req_kind_e kind;
  logic      fire;

  assign fire = term && !restart;

  always_comb begin
    kind = REQ_NONE;
    if (fire) kind = lowpwr ? REQ_WAKE : REQ_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      rst_req  <= (kind == REQ_RESET);
      wake_req <= (kind == REQ_WAKE);
      to_flag  <= (to_flag && !flag_clr) || fire;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int SHORT_LOG = PRE_SHORT_LOG,
  parameter int LONG_LOG  = PRE_LONG_LOG,
  parameter int SW        = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pre_long,
  input  logic [SW-1:0] post_sel,
  input  logic          sw_clr,
  input  logic          clk_sw_done,
  input  logic          lp_enter,
  input  logic          lp_exit,
  input  logic          in_lowpower,
  input  logic          flag_clr,
  output logic          osc_en,
  output logic          rst_req,
  output logic          wake_req,
  output logic          to_flag
);
  logic restart;
  logic hold_zero;
  logic pre_tick;
  logic post_term;

  assign restart   = sw_clr | clk_sw_done | lp_enter | lp_exit;
  assign hold_zero = restart | ~en;
  assign osc_en    = en;

  wdog_prescale #(.SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en),
    .clr      (restart),
    .long_sel (pre_long),
    .tick     (pre_tick)
  );

  wdog_postscale #(.SEL_W(SW)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold_zero),
    .tick  (pre_tick),
    .sel   (post_sel),
    .term  (post_term)
  );

  wdog_report u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .term     (post_term),
    .restart  (restart),
    .lowpwr   (in_lowpower),
    .flag_clr (flag_clr),
    .rst_req  (rst_req),
    .wake_req (wake_req),
    .to_flag  (to_flag)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sw_clr,
  input logic clk_sw_done,
  input logic lp_enter,
  input logic lp_exit,
  input logic in_lowpower,
  input logic flag_clr,
  input logic rst_req,
  input logic wake_req,
  input logic to_flag
);
  p_excl_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, wake_req}));

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_rst_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(in_lowpower));

  p_wake_in_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(in_lowpower));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_clr | clk_sw_done | lp_enter | lp_exit) |-> !(rst_req || wake_req));

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !(rst_req || wake_req));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(to_flag) && !$past(flag_clr)) |-> to_flag);

  p_req_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> to_flag);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .sw_clr      (sw_clr),
  .clk_sw_done (clk_sw_done),
  .lp_enter    (lp_enter),
  .lp_exit     (lp_exit),
  .in_lowpower (in_lowpower),
  .flag_clr    (flag_clr),
  .rst_req     (rst_req),
  .wake_req    (wake_req),
  .to_flag     (to_flag)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       pre_long = 1'b0;
  logic [3:0] post_sel = 4'd0;
  logic       sw_clr = 1'b0;
  logic       clk_sw_done = 1'b0;
  logic       lp_enter = 1'b0;
  logic       lp_exit = 1'b0;
  logic       in_lowpower = 1'b0;
  logic       flag_clr = 1'b0;
  logic       osc_en, rst_req, wake_req, to_flag;

  always #4 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_long(pre_long), .post_sel(post_sel),
    .sw_clr(sw_clr), .clk_sw_done(clk_sw_done), .lp_enter(lp_enter),
    .lp_exit(lp_exit), .in_lowpower(in_lowpower), .flag_clr(flag_clr),
    .osc_en(osc_en), .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
  );

  typedef struct { int cyc; bit wake; string tag; } exp_t;
  exp_t q[$];
  int   cyc = 0;
  int   cur_t = 32;
  bit   cur_lp = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: one sample per cycle, 2 ns after the rising edge
  initial forever begin
    @(posedge clk);
    cyc++;
    #2;
    if (rst_req || wake_req) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected request", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.cyc == cyc, {e.tag, " timeout cycle"}, cyc, e.cyc);
        chk(e.wake == wake_req, {e.tag, " R6 request kind (1=wake)"}, wake_req, e.wake);
        q.push_back('{cyc + cur_t, cur_lp, "R5 periodic"});
      end
    end else if (q.size() > 0 && q[0].cyc <= cyc) begin
      chk(1'b0, {q[0].tag, " missed timeout"}, -1, q[0].cyc);
      void'(q.pop_front());
    end
  end

  // caller is at a falling edge; one-cycle restart strobe
  task automatic strobe(int which, string tag);
    case (which)
      0: sw_clr = 1'b1;
      1: clk_sw_done = 1'b1;
      2: lp_enter = 1'b1;
      default: lp_exit = 1'b1;
    endcase
    q.delete();
    q.push_back('{cyc + 1 + cur_t, cur_lp, tag});
    @(negedge clk);
    sw_clr = 1'b0; clk_sw_done = 1'b0; lp_enter = 1'b0; lp_exit = 1'b0;
  endtask

  task automatic wait_terminal();
    while (cyc != q[0].cyc - 1) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rst_req && !wake_req && !to_flag, "R10 outputs in reset", {rst_req, wake_req, to_flag}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!rst_req && !wake_req && !to_flag, "R10 outputs after reset", {rst_req, wake_req, to_flag}, 0);
    chk(osc_en == 1'b0, "R9 osc_en off", osc_en, 0);

    // R8/R1: enable, short prescale, N=0
    cur_t = 32; cur_lp = 1'b0;
    en = 1'b1;
    q.delete();
    q.push_back('{cyc + cur_t, 1'b0, "R8 R1 first after enable"});
    #1 chk(osc_en == 1'b1, "R9 osc_en on", osc_en, 1);
    repeat (100) @(negedge clk);
    chk(to_flag == 1'b1, "R7 flag set", to_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(to_flag == 1'b0, "R7 flag cleared", to_flag, 0);

    // R2: long prescale, N=3, changed at a restart
    pre_long = 1'b1; post_sel = 4'd3; cur_t = 1024;
    strobe(0, "R2 R1 long N=3");
    repeat (2100) @(negedge clk);

    // R3: clock-switch restart mid-period
    repeat (500) @(negedge clk);
    strobe(1, "R3 clock switch restart");
    repeat (1100) @(negedge clk);

    // R6: low-power entry restarts, timeouts become wake requests
    in_lowpower = 1'b1; cur_lp = 1'b1;
    strobe(2, "R6 wake in low power");
    repeat (2100) @(negedge clk);
    repeat (300) @(negedge clk);
    in_lowpower = 1'b0; cur_lp = 1'b0;
    strobe(3, "R3 low-power exit restart");
    repeat (1100) @(negedge clk);

    // R4: clear in the terminal-count cycle
    pre_long = 1'b0; post_sel = 4'd0; cur_t = 32;
    strobe(0, "R1 short N=0");
    wait_terminal();
    strobe(0, "R4 clear beats terminal");
    repeat (80) @(negedge clk);

    // R7: flag clear on the timeout edge leaves the flag set
    wait_terminal();
    flag_clr = 1'b1;
    @(posedge clk); #2;
    chk(to_flag == 1'b1, "R7 set beats clear", to_flag, 1);
    @(negedge clk);
    flag_clr = 1'b0;

    // R8: disabled is quiet, re-enable counts from zero
    en = 1'b0;
    q.delete();
    #1 chk(osc_en == 1'b0, "R9 osc_en follows disable", osc_en, 0);
    repeat (300) @(negedge clk);
    pre_long = 1'b1; post_sel = 4'd0; cur_t = 128;
    en = 1'b1;
    q.push_back('{cyc + cur_t, 1'b0, "R8 re-enable"});
    repeat (300) @(negedge clk);

    // R2: larger exponent, N=8
    pre_long = 1'b0; post_sel = 4'd8; cur_t = 8192;
    strobe(0, "R2 N=8");
    repeat (8300) @(negedge clk);

    // R3/R10: device reset mid-period
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    chk(!rst_req && !wake_req && !to_flag, "R10 reset clears outputs", {rst_req, wake_req, to_flag}, 0);
    rst_n = 1'b1;
    q.push_back('{cyc + cur_t, 1'b0, "R3 after device reset"});
    repeat (8300) @(negedge clk);

    done = 1'b1;
    report();
  end
endmodule